// File: doc/BRIEF.md
# Coherent DMA request controller

This block is a DMA engine that handles one transaction at a time. It sits between a DMA sequencer and a directory-based coherence fabric. In its idle state it accepts one load or store from the sequencer. It turns that request into a read or write request to the directory and then stops taking new work until the transaction completes.

While a transaction is open, the block decodes the directory's responses. It keeps a signed count of outstanding acknowledgements. When that count lands on zero, the block posts a one-entry internal trigger to itself.

A load completes in one of two ways. Either a data response arrives, or the trigger fires and the block returns the data held in its record. In both cases the sequencer sees a data callback strobe. A store completes only through the trigger. It raises a write-ack strobe and sends an exclusive-unblock message back to the directory.

Both outgoing message streams pass through fixed delay lines of configurable length. Any response that does not fit the current state sets a sticky error flag and leaves the state alone.

Top module: `dma_coh_ctrl`

## Requirements
- R1: After reset the block is idle. `sq_ready` and `drsp_ready` are 1, and `dreq_valid`, `dunb_valid`, `cb_data_valid`, `cb_wack_valid` and `err` are 0.
- R2: In idle, a load (`sq_is_store`=0) is accepted when `sq_valid` is 1. It produces a directory request with `dreq_is_write`=0 that carries the request's address, length and data, with `dreq_src` equal to `REQ_ID`. `sq_ready` then stays 0 until the transaction completes.
- R3: In idle, a store (`sq_is_store`=1) is accepted in the same way, with `dreq_is_write`=1, and it also holds `sq_ready` at 0 until completion.
- R4: `dreq_valid` is a one-cycle pulse that appears exactly `REQ_LAT` cycles after the cycle in which the request was accepted.
- R5: The response type is encoded as follows: 0 is data, 1 is exclusive data (treated as data), 2 is an invalidation ack and 3 is a DMA ack. Codes 4 to 7 set `err` and cause no other action.
- R6: An invalidation ack in either busy state subtracts the signed `drsp_acks` from a pending counter that clears to 0 when a transaction is allocated. If the result is 0, an internal trigger is posted. No completion occurs before the trigger is serviced.
- R7: In a store transaction, a DMA ack also subtracts `drsp_acks`. A negative value raises the count, and no trigger is posted while the count is nonzero.
- R8: In a load transaction, a data response produces `cb_data_valid` with `cb_data` equal to the response data in the next cycle, together with `sq_ready`=1. No unblock is ever sent for it.
- R9: When the trigger is serviced in a load transaction, `cb_data_valid` pulses with the record's data block, which is zero at allocation. The block returns to idle and sends no unblock.
- R10: When the trigger is serviced in a store transaction, `cb_wack_valid` pulses in the next cycle. `dunb_valid` with `dunb_addr` equal to the transaction address follows `RSP_LAT` cycles after the trigger cycle. The two callback strobes are never high together.
- R11: The trigger is serviced in the cycle after the response that posted it. `drsp_ready` is 0 during that cycle, so the trigger wins over any response.
- R12: An unexpected event sets a sticky `err` and leaves the state unchanged. Unexpected events are: a response in idle, a data response in a store transaction, and a DMA ack in a load transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sq_valid | input | 1 | Sequencer request present |
| sq_ready | output | 1 | Block is idle and takes a request |
| sq_is_store | input | 1 | 1 = store, 0 = load |
| sq_addr | input | ADDR_W | Physical address |
| sq_len | input | LEN_W | Transfer length |
| sq_data | input | DATA_W | Store data block |
| dreq_valid | output | 1 | Directory request pulse |
| dreq_is_write | output | 1 | 1 = DMA write, 0 = DMA read |
| dreq_addr | output | ADDR_W | Request address |
| dreq_len | output | LEN_W | Request length |
| dreq_data | output | DATA_W | Request data |
| dreq_src | output | ID_W | Requester identifier |
| drsp_valid | input | 1 | Directory response present |
| drsp_ready | output | 1 | Response accepted this cycle |
| drsp_type | input | 3 | Response type code |
| drsp_acks | input | ACK_W | Signed ack count |
| drsp_data | input | DATA_W | Response data block |
| dunb_valid | output | 1 | Exclusive-unblock pulse to directory |
| dunb_addr | output | ADDR_W | Unblock address |
| cb_data_valid | output | 1 | Data callback strobe |
| cb_data | output | DATA_W | Data callback block |
| cb_wack_valid | output | 1 | Write-ack callback strobe |
| err | output | 1 | Sticky protocol error |

## Verification
The assertions take it for granted that the directory only offers a response when `drsp_ready` is high. They also assume the sequencer keeps `sq_valid` meaningful only while it waits for the block.

The stimulus follows these rules. Each response is driven for one accepted cycle. Ack sequences are built so that the running count reaches zero only on their last message: a single signed raise is followed by unit decrements. Every transaction waits out its full completion before the next one begins.

Protocol violations appear only in separate directed runs, each started from a fresh reset, so the sticky error cannot hide a later fault.

// File: rtl/dma_coh_ctrl.sv
module dma_coh_ctrl #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int LEN_W   = 8,
  parameter int ID_W    = 4,
  parameter int ACK_W   = 8,
  parameter int CNT_W   = 12,
  parameter int REQ_LAT = 14,
  parameter int RSP_LAT = 14,
  parameter int REQ_ID  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sq_valid,
  output logic              sq_ready,
  input  logic              sq_is_store,
  input  logic [ADDR_W-1:0] sq_addr,
  input  logic [LEN_W-1:0]  sq_len,
  input  logic [DATA_W-1:0] sq_data,
  output logic              dreq_valid,
  output logic              dreq_is_write,
  output logic [ADDR_W-1:0] dreq_addr,
  output logic [LEN_W-1:0]  dreq_len,
  output logic [DATA_W-1:0] dreq_data,
  output logic [ID_W-1:0]   dreq_src,
  input  logic              drsp_valid,
  output logic              drsp_ready,
  input  logic [2:0]        drsp_type,
  input  logic [ACK_W-1:0]  drsp_acks,
  input  logic [DATA_W-1:0] drsp_data,
  output logic              dunb_valid,
  output logic [ADDR_W-1:0] dunb_addr,
  output logic              cb_data_valid,
  output logic [DATA_W-1:0] cb_data,
  output logic              cb_wack_valid,
  output logic              err
);
  localparam int RQ_W = 1 + ADDR_W + LEN_W + DATA_W;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_t;

  st_t                     st;
  logic                    trig;
  logic signed [CNT_W-1:0] cnt;
  logic signed [CNT_W-1:0] acks_ext;
  logic signed [CNT_W-1:0] cnt_sub;
  logic [DATA_W-1:0]       blk;
  logic [ADDR_W-1:0]       addr_q;

  logic acc, rsp_fire, is_data, is_ack, is_dack, bad_type, unexp, unb_push;

  assign sq_ready   = (st == ST_IDLE);
  assign drsp_ready = !trig;
  assign acc        = sq_valid && sq_ready;
  assign rsp_fire   = drsp_valid && drsp_ready;

  assign is_data  = (drsp_type == 3'd0) || (drsp_type == 3'd1);
  assign is_ack   = (drsp_type == 3'd2);
  assign is_dack  = (drsp_type == 3'd3);
  assign bad_type = drsp_type[2];

  assign unexp = rsp_fire && (bad_type || st == ST_IDLE ||
                              (is_dack && st == ST_RD) ||
                              (is_data && st == ST_WR));

  assign acks_ext = {{(CNT_W-ACK_W){drsp_acks[ACK_W-1]}}, drsp_acks};
  assign cnt_sub  = cnt - acks_ext;
  assign unb_push = trig && (st == ST_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      trig          <= 1'b0;
      cnt           <= '0;
      blk           <= '0;
      addr_q        <= '0;
      err           <= 1'b0;
      cb_data_valid <= 1'b0;
      cb_wack_valid <= 1'b0;
      cb_data       <= '0;
    end else begin
      cb_data_valid <= 1'b0;
      cb_wack_valid <= 1'b0;
      trig          <= 1'b0;
      if (unexp) err <= 1'b1;
      if (trig) begin
        if (st == ST_RD) begin
          cb_data_valid <= 1'b1;
          cb_data       <= blk;
        end else if (st == ST_WR) begin
          cb_wack_valid <= 1'b1;
        end
        st <= ST_IDLE;
      end else if (acc) begin
        st     <= sq_is_store ? ST_WR : ST_RD;
        cnt    <= '0;
        blk    <= '0;
        addr_q <= sq_addr;
      end else if (rsp_fire && !unexp) begin
        if (is_ack || is_dack) begin
          cnt <= cnt_sub;
          if (cnt_sub == '0) trig <= 1'b1;
        end else if (is_data) begin
          blk           <= drsp_data;
          cb_data_valid <= 1'b1;
          cb_data       <= drsp_data;
          st            <= ST_IDLE;
        end
      end
    end
  end

  logic [REQ_LAT-1:0] rq_v;
  logic [RQ_W-1:0]    rq_p [REQ_LAT];
  logic [RSP_LAT-1:0] ub_v;
  logic [ADDR_W-1:0]  ub_p [RSP_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_v <= '0;
      ub_v <= '0;
    end else begin
      rq_v[0] <= acc;
      ub_v[0] <= unb_push;
      for (int i = 1; i < REQ_LAT; i++) rq_v[i] <= rq_v[i-1];
      for (int i = 1; i < RSP_LAT; i++) ub_v[i] <= ub_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    rq_p[0] <= {sq_is_store, sq_addr, sq_len, sq_data};
    ub_p[0] <= addr_q;
    for (int i = 1; i < REQ_LAT; i++) rq_p[i] <= rq_p[i-1];
    for (int i = 1; i < RSP_LAT; i++) ub_p[i] <= ub_p[i-1];
  end

  assign dreq_valid = rq_v[REQ_LAT-1];
  assign {dreq_is_write, dreq_addr, dreq_len, dreq_data} = rq_p[REQ_LAT-1];
  assign dreq_src   = ID_W'(REQ_ID);
  assign dunb_valid = ub_v[RSP_LAT-1];
  assign dunb_addr  = ub_p[RSP_LAT-1];

  assert_accept_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !sq_ready);

  assert_trig_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (sq_ready && !trig));

  assert_cb_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cb_data_valid && cb_wack_valid));

  assert_wack_after_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cb_wack_valid |-> $past(trig));

  assert_data_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && st == ST_RD && is_data) |=> (cb_data_valid && sq_ready));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_bad_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && bad_type) |=> err);
endmodule

// File: tb/sim_dma_coh_ctrl.sv
module sim_dma_coh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_Q = 14;
  localparam int LAT_U = 14;
  localparam int MY_ID = 5;

  logic clk = 0, rst_n = 0;
  logic sq_valid = 0, sq_is_store = 0;
  logic [31:0] sq_addr = 0;
  logic [7:0]  sq_len = 0;
  logic [63:0] sq_data = 0;
  logic drsp_valid = 0;
  logic [2:0]  drsp_type = 0;
  logic [7:0]  drsp_acks = 0;
  logic [63:0] drsp_data = 0;
  logic sq_ready, dreq_valid, dreq_is_write, drsp_ready, dunb_valid;
  logic cb_data_valid, cb_wack_valid, err;
  logic [31:0] dreq_addr, dunb_addr;
  logic [7:0]  dreq_len;
  logic [63:0] dreq_data, cb_data;
  logic [3:0]  dreq_src;

  int errors = 0, checks = 0;
  int mcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_coh_ctrl #(.REQ_LAT(LAT_Q), .RSP_LAT(LAT_U), .REQ_ID(MY_ID)) u0 (
    .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_ready(sq_ready),
    .sq_is_store(sq_is_store), .sq_addr(sq_addr), .sq_len(sq_len), .sq_data(sq_data),
    .dreq_valid(dreq_valid), .dreq_is_write(dreq_is_write), .dreq_addr(dreq_addr),
    .dreq_len(dreq_len), .dreq_data(dreq_data), .dreq_src(dreq_src),
    .drsp_valid(drsp_valid), .drsp_ready(drsp_ready), .drsp_type(drsp_type),
    .drsp_acks(drsp_acks), .drsp_data(drsp_data), .dunb_valid(dunb_valid),
    .dunb_addr(dunb_addr), .cb_data_valid(cb_data_valid), .cb_data(cb_data),
    .cb_wack_valid(cb_wack_valid), .err(err));

  function automatic int model_sub(input int c, input int a);
    return c - a;
  endfunction

  function automatic logic [63:0] exp_read(input bit via_data, input logic [63:0] d);
    return via_data ? d : 64'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; sq_valid = 0; drsp_valid = 0;
    repeat (3) step();
    rst_n = 1;
    step();
  endtask

  task automatic send_req(input bit st, input logic [31:0] a, input logic [7:0] l, input logic [63:0] d);
    sq_valid = 1; sq_is_store = st; sq_addr = a; sq_len = l; sq_data = d;
    chk(sq_ready, "R2 ready in idle", 64'(sq_ready), 1);
    step();
    sq_valid = 0;
    chk(!sq_ready, st ? "R3 busy holds off" : "R2 busy holds off", 64'(sq_ready), 0);
    for (int i = 1; i < LAT_Q; i++) begin
      if (i == LAT_Q - 1) chk(!dreq_valid, "R4 no early request", 64'(dreq_valid), 0);
      step();
    end
    chk(dreq_valid, "R4 request timing", 64'(dreq_valid), 1);
    chk(dreq_is_write == st, st ? "R3 write kind" : "R2 read kind", 64'(dreq_is_write), 64'(st));
    chk(dreq_addr == a && dreq_len == l, "R2 addr/len", {dreq_addr, 24'd0, dreq_len}, {a, 24'd0, l});
    chk(dreq_data == d, "R2 data", dreq_data, d);
    chk(dreq_src == 4'(MY_ID), "R2 source id", 64'(dreq_src), 64'(MY_ID));
    step();
    chk(!dreq_valid, "R4 single pulse", 64'(dreq_valid), 0);
    mcnt = 0;
  endtask

  task automatic send_rsp(input logic [2:0] t, input int acks, input logic [63:0] d);
    drsp_valid = 1; drsp_type = t; drsp_acks = 8'(acks); drsp_data = d;
    chk(drsp_ready, "R11 response accepted", 64'(drsp_ready), 1);
    step();
    drsp_valid = 0;
  endtask

  task automatic no_unblock(input int n);
    for (int i = 0; i < n; i++) begin
      chk(!dunb_valid, "R9 no unblock", 64'(dunb_valid), 0);
      step();
    end
  endtask

  task automatic ack_msg(input logic [2:0] t, input int acks, input bit wr, input logic [31:0] a);
    mcnt = model_sub(mcnt, acks);
    send_rsp(t, acks, 64'd0);
    if (mcnt != 0) begin
      chk(!cb_data_valid && !cb_wack_valid && !sq_ready, wr ? "R7 no early completion" : "R6 no early completion",
          {cb_data_valid, cb_wack_valid, sq_ready}, 0);
      return;
    end
    chk(!drsp_ready, "R11 trigger blocks response", 64'(drsp_ready), 0);
    chk(!cb_data_valid && !cb_wack_valid, "R11 not yet complete", {cb_data_valid, cb_wack_valid}, 0);
    step();
    if (wr) begin
      chk(cb_wack_valid && !cb_data_valid, "R10 write ack", {cb_data_valid, cb_wack_valid}, 1);
      chk(sq_ready, "R10 back to idle", 64'(sq_ready), 1);
      for (int i = 0; i < LAT_U - 1; i++) begin
        chk(!dunb_valid, "R10 no early unblock", 64'(dunb_valid), 0);
        step();
      end
      chk(dunb_valid && dunb_addr == a, "R10 unblock", {dunb_valid, dunb_addr}, {1'b1, a});
      step();
      chk(!dunb_valid, "R10 unblock pulse", 64'(dunb_valid), 0);
    end else begin
      chk(cb_data_valid && !cb_wack_valid, "R9 data callback", {cb_data_valid, cb_wack_valid}, 2);
      chk(cb_data == exp_read(0, 64'd0), "R9 record data", cb_data, 0);
      chk(sq_ready, "R9 back to idle", 64'(sq_ready), 1);
      no_unblock(LAT_U + 1);
    end
  endtask

  task automatic data_msg(input logic [2:0] t, input logic [63:0] d);
    send_rsp(t, 0, d);
    chk(cb_data_valid && cb_data == exp_read(1, d), "R8 data callback", cb_data, d);
    chk(sq_ready && !cb_wack_valid, "R8 idle after data", {sq_ready, cb_wack_valid}, 2);
    no_unblock(LAT_U + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    chk(sq_ready && drsp_ready, "R1 ready after reset", {sq_ready, drsp_ready}, 3);
    chk(!dreq_valid && !dunb_valid && !cb_data_valid && !cb_wack_valid && !err, "R1 quiet after reset",
        {dreq_valid, dunb_valid, cb_data_valid, cb_wack_valid, err}, 0);

    for (int n = 0; n < 40; n++) begin
      bit st = 1'($urandom);
      logic [31:0] a = $urandom;
      logic [7:0] l = 8'($urandom);
      logic [63:0] d = {$urandom, $urandom};
      int k = $urandom_range(0, 3);
      int mode = $urandom_range(0, 2);
      send_req(st, a, l, d);
      if (st) begin
        if (k == 0) ack_msg(3'd3, 0, 1, a);
        else begin
          ack_msg(3'd3, -k, 1, a);
          for (int j = 0; j < k; j++) ack_msg(($urandom_range(0, 1) != 0) ? 3'd2 : 3'd3, 1, 1, a);
        end
      end else if (mode == 0) begin
        data_msg(3'($urandom_range(0, 1)), {$urandom, $urandom});
      end else if (k == 0) begin
        ack_msg(3'd2, 0, 0, a);
      end else begin
        ack_msg(3'd2, -k, 0, a);
        if (mode == 1) data_msg(3'd0, {$urandom, $urandom});
        else for (int j = 0; j < k; j++) ack_msg(3'd2, 1, 0, a);
      end
    end
    chk(!err, "R5 valid codes raise no error", 64'(err), 0);

    send_rsp(3'd2, 0, 64'd0);
    chk(err, "R12 response in idle", 64'(err), 1);
    chk(sq_ready && !cb_data_valid, "R12 idle kept", {sq_ready, cb_data_valid}, 2);

    do_reset();
    send_req(0, 32'h1000, 8'd4, 64'h11);
    send_rsp(3'd6, 0, 64'hAB);
    chk(err, "R5 bad type error", 64'(err), 1);
    chk(!sq_ready && !cb_data_valid, "R5 bad type ignored", {sq_ready, cb_data_valid}, 0);
    data_msg(3'd1, 64'hCAFE_F00D);

    do_reset();
    send_req(1, 32'h2040, 8'd8, 64'h22);
    send_rsp(3'd0, 0, 64'h33);
    chk(err, "R12 data in write", 64'(err), 1);
    chk(!sq_ready && !cb_data_valid, "R12 write state kept", {sq_ready, cb_data_valid}, 0);
    ack_msg(3'd3, 0, 1, 32'h2040);

    do_reset();
    send_req(0, 32'h3080, 8'd2, 64'h44);
    send_rsp(3'd3, 5, 64'h0);
    chk(err, "R12 dma ack in read", 64'(err), 1);
    chk(!sq_ready && !cb_data_valid, "R12 read state kept", {sq_ready, cb_data_valid}, 0);
    ack_msg(3'd2, 0, 0, 32'h3080);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule